// File: doc/BRIEF.md
# LVDS Word Alignment Controller

This block runs the start-up alignment of a multi-lane LVDS ADC receiver. It looks at the word captured from the frame lane and at the two channel words. It drives the two controls that the capture logic accepts: a bitslip request and a load of a delay tap. After one start pulse it runs three phases in a fixed order. First it slips the deserialiser until the frame word has the expected low nibble. Then it steps the input delay tap upward from zero until the frame word changes, and sets the tap to a centre value derived from the tap where the change appeared. Last it watches both channels for a fixed number of samples while the converter sends a known test pattern.

The deserialiser and the delay line are outside this block. After every bitslip pulse and every tap load, the controller waits a programmable number of settle cycles before it trusts the captured data again. When the run ends, the block reports done together with exactly one of aligned or error. The status holds until the next accepted start.

Top module: `lvds_align_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it falls, bitslip_o, tap_load_o, done_o, aligned_o and error_o are 0 and tap_o is 0.
- R2: A frame word counts as aligned when bits [3:0] equal 4'hC. A bitslip pulse is issued only after an evaluation that found the frame misaligned. An evaluation that finds it aligned ends the slip phase and stores that frame word as the sweep reference.
- R3: Each bitslip pulse is high for exactly one cycle, and at most MAX_SLIPS pulses are issued per run. If the evaluation after the last allowed pulse still finds the frame misaligned, the run ends in error and no tap is loaded.
- R4: The sweep loads taps 0, 1, 2, ... in turn, each with a one-cycle tap_load_o strobe. tap_o changes only in a cycle in which tap_load_o is high. At each tap the frame word is compared with the previous sample (the reference for tap 0), and the stored sample is then replaced.
- R5: When the frame word first differs at tap t, the block loads tap ((t+1) div 2) + 2 and goes on to the pattern check.
- R6: If the frame word never differs over taps 0 to 31, the run ends in error with tap_o left at 31.
- R7: The frame or channel words are evaluated on the clock edge SETTLE_CYC+1 cycles after the edge that issued a bitslip pulse or a tap load.
- R8: The pattern check samples both channels on CHECK_LEN consecutive cycles and passes only if every sample equals TEST_PATTERN (16'h811F by default). The first mismatch ends the run in error on that edge.
- R9: When a run ends, done_o is set. aligned_o is set only if the slip, sweep and check phases all passed, and error_o is set otherwise. The two are never high together, and all three are cleared on the edge that accepts a start.
- R10: start_i is acted on only when the block is idle. Holding it high during a run does not change that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an alignment run (sampled when idle) |
| frame_i | input | 8 | Deserialised frame-lane word |
| ch0_i | input | 16 | Channel 0 data word |
| ch1_i | input | 16 | Channel 1 data word |
| bitslip_o | output | 1 | One-cycle bitslip request |
| tap_o | output | 5 | Delay tap value for the data lanes |
| tap_load_o | output | 1 | One-cycle strobe to load tap_o |
| done_o | output | 1 | Run finished |
| aligned_o | output | 1 | All phases passed |
| error_o | output | 1 | A phase failed |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle width of the bitslip and load strobes, that the tap moves only under its strobe, that a good frame never causes a slip, that a channel mismatch ends the run with an error, and that aligned and error never appear together. Other behaviour only shows in the bench's scenarios. That covers the limit on slips, the centre-tap formula, a sweep that finds no edge, a mismatch on the first or last sample, and a start held high through a run. The bench drives a model of the capture path that reacts to the slip and load requests and compares every output against a behavioural model on each clock.

// File: rtl/lvds_align_pkg.sv
package lvds_align_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLIP_EVAL,
    ST_SLIP_WAIT,
    ST_TAP_WAIT,
    ST_TAP_EVAL,
    ST_CHK_WAIT,
    ST_CHK_RUN
  } align_state_e;

endpackage

// File: rtl/la_settle_timer.sv
module la_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CW'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || last_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end

  AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !run_i); // R7

endmodule

// File: rtl/la_frame_tracker.sv
module la_frame_tracker #(
  parameter int         FRAME_W     = 8,
  parameter logic [3:0] GOOD_NIBBLE = 4'hC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               good_o,
  output logic               changed_o
);
  logic [FRAME_W-1:0] ref_q;

  assign good_o    = (frame_i[3:0] == GOOD_NIBBLE);
  assign changed_o = (frame_i != ref_q);

  always_ff @(posedge clk) begin
    if (rst)            ref_q <= '0;
    else if (capture_i) ref_q <= frame_i;
  end

endmodule

// File: rtl/la_pattern_check.sv
module la_pattern_check #(
  parameter int              CH_W         = 16,
  parameter int              CHECK_LEN    = 100,
  parameter logic [CH_W-1:0] TEST_PATTERN = 16'h811F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [CH_W-1:0] ch0_i,
  input  logic [CH_W-1:0] ch1_i,
  output logic            bad_o,
  output logic            last_o
);
  localparam int CW = (CHECK_LEN > 1) ? $clog2(CHECK_LEN) : 1;

  logic [CW-1:0] cnt_q;

  assign bad_o  = run_i && ((ch0_i != TEST_PATTERN) || (ch1_i != TEST_PATTERN));
  assign last_o = run_i && (cnt_q == CW'(CHECK_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || bad_o || last_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + CW'(1);
  end

  AST_CHECK_STOPS: assert property (@(posedge clk) disable iff (rst)
    bad_o |=> !run_i); // R8

endmodule

// File: rtl/lvds_align_ctrl.sv
module lvds_align_ctrl
  import lvds_align_pkg::*;
#(
  parameter int              FRAME_W      = 8,
  parameter int              CH_W         = 16,
  parameter int              TAP_W        = 5,
  parameter int              MAX_SLIPS    = 4,
  parameter int              SETTLE_CYC   = 4,
  parameter int              CHECK_LEN    = 100,
  parameter logic [CH_W-1:0] TEST_PATTERN = 16'h811F,
  parameter logic [3:0]      GOOD_NIBBLE  = 4'hC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CH_W-1:0]    ch0_i,
  input  logic [CH_W-1:0]    ch1_i,
  output logic               bitslip_o,
  output logic [TAP_W-1:0]   tap_o,
  output logic               tap_load_o,
  output logic               done_o,
  output logic               aligned_o,
  output logic               error_o
);
  localparam int               SLIP_CW  = $clog2(MAX_SLIPS + 1);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  align_state_e       state_q;
  logic [SLIP_CW-1:0] slip_cnt_q;
  logic [TAP_W-1:0]   tap_q;
  logic               slip_q, load_q, done_q, aligned_q, err_q;

  logic settle_run, settle_last;
  logic frame_capture, frame_good, frame_changed;
  logic chk_run, chk_bad, chk_last;
  logic [TAP_W-1:0] centre_tap;

  // ((t+1) div 2) equals (t div 2) plus the low bit of t
  assign centre_tap = {1'b0, tap_q[TAP_W-1:1]} + TAP_W'(tap_q[0]) + TAP_W'(2);

  assign settle_run    = (state_q == ST_SLIP_WAIT) || (state_q == ST_TAP_WAIT) ||
                         (state_q == ST_CHK_WAIT);
  assign frame_capture = ((state_q == ST_SLIP_EVAL) && frame_good) ||
                         (state_q == ST_TAP_EVAL);
  assign chk_run       = (state_q == ST_CHK_RUN);

  la_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .run_i  (settle_run),
    .last_o (settle_last)
  );

  la_frame_tracker #(.FRAME_W(FRAME_W), .GOOD_NIBBLE(GOOD_NIBBLE)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .capture_i (frame_capture),
    .frame_i   (frame_i),
    .good_o    (frame_good),
    .changed_o (frame_changed)
  );

  la_pattern_check #(.CH_W(CH_W), .CHECK_LEN(CHECK_LEN), .TEST_PATTERN(TEST_PATTERN)) u_check (
    .clk    (clk),
    .rst    (rst),
    .run_i  (chk_run),
    .ch0_i  (ch0_i),
    .ch1_i  (ch1_i),
    .bad_o  (chk_bad),
    .last_o (chk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      slip_cnt_q <= '0;
      tap_q      <= '0;
      slip_q     <= 1'b0;
      load_q     <= 1'b0;
      done_q     <= 1'b0;
      aligned_q  <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      slip_q <= 1'b0;
      load_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_SLIP_EVAL;
            slip_cnt_q <= '0;
            done_q     <= 1'b0;
            aligned_q  <= 1'b0;
            err_q      <= 1'b0;
          end
        end
        ST_SLIP_EVAL: begin
          if (frame_good) begin
            tap_q   <= '0;
            load_q  <= 1'b1;
            state_q <= ST_TAP_WAIT;
          end else if (slip_cnt_q == SLIP_CW'(MAX_SLIPS)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            slip_q     <= 1'b1;
            slip_cnt_q <= slip_cnt_q + SLIP_CW'(1);
            state_q    <= ST_SLIP_WAIT;
          end
        end
        ST_SLIP_WAIT: if (settle_last) state_q <= ST_SLIP_EVAL;
        ST_TAP_WAIT:  if (settle_last) state_q <= ST_TAP_EVAL;
        ST_TAP_EVAL: begin
          if (frame_changed) begin
            tap_q   <= centre_tap;
            load_q  <= 1'b1;
            state_q <= ST_CHK_WAIT;
          end else if (tap_q == TAP_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            tap_q   <= tap_q + TAP_W'(1);
            load_q  <= 1'b1;
            state_q <= ST_TAP_WAIT;
          end
        end
        ST_CHK_WAIT: if (settle_last) state_q <= ST_CHK_RUN;
        ST_CHK_RUN: begin
          if (chk_bad) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else if (chk_last) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            aligned_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bitslip_o  = slip_q;
  assign tap_o      = tap_q;
  assign tap_load_o = load_q;
  assign done_o     = done_q;
  assign aligned_o  = aligned_q;
  assign error_o    = err_q;

  AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bitslip_o |=> !bitslip_o); // R3
  AST_NO_SLIP_WHEN_GOOD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLIP_EVAL && frame_i[3:0] == GOOD_NIBBLE) |=> !bitslip_o); // R2
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tap_load_o |=> !tap_load_o); // R4
  AST_TAP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(tap_o) |-> tap_load_o); // R4
  AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHK_RUN && (ch0_i != TEST_PATTERN || ch1_i != TEST_PATTERN))
      |=> (done_o && error_o)); // R8
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(aligned_o && error_o)); // R9
  AST_ALIGNED_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
    aligned_o |-> done_o); // R9

endmodule

// File: tb/tb_lvds_align_ctrl.sv
module tb_lvds_align_ctrl;
  localparam int          SETTLE = 4;
  localparam int          SLIPS  = 4;
  localparam int          CHK    = 100;
  localparam logic [15:0] PAT    = 16'h811F;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0]  frame = 8'h00;
  logic [15:0] ch0 = 16'h0, ch1 = 16'h0;
  logic        bitslip, tap_load, done, aligned, error;
  logic [4:0]  tap;

  lvds_align_ctrl #(.SETTLE_CYC(SETTLE), .MAX_SLIPS(SLIPS), .CHECK_LEN(CHK),
                    .TEST_PATTERN(PAT)) dut (
    .clk(clk), .rst(rst), .start_i(start), .frame_i(frame), .ch0_i(ch0), .ch1_i(ch1),
    .bitslip_o(bitslip), .tap_o(tap), .tap_load_o(tap_load),
    .done_o(done), .aligned_o(aligned), .error_o(error));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // capture-path model: slips rotate the frame, taps at or past edge_tap flip its top nibble
  int slips = 0, cur_tap = 0, edge_tap = 99, since_load = 0, bad_at = -1;
  logic [7:0] base = 8'h0C;

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    logic [7:0] r = v;
    for (int i = 0; i < (n % 8); i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  always @(negedge clk) begin
    if (bitslip) slips = slips + 1;
    if (tap_load) begin cur_tap = int'(tap); since_load = 0; end
    else since_load = since_load + 1;
    frame = rotl(base, slips) ^ ((cur_tap >= edge_tap) ? 8'hF0 : 8'h00);
    ch0 = PAT;
    ch1 = PAT;
    if (bad_at >= 0 && since_load == SETTLE + bad_at) ch1 = PAT ^ 16'h0004;
  end

  // expected outputs, compared on every falling edge
  logic e_slip = 0, e_load = 0, e_done = 0, e_al = 0, e_err = 0;
  int   e_tap = 0;

  always @(negedge clk) if (!rst) begin
    chk("R3 bitslip_o", int'(bitslip), int'(e_slip));
    chk("R4 tap_load_o", int'(tap_load), int'(e_load));
    chk("R5 tap_o", int'(tap), e_tap);
    chk("R9 done_o", int'(done), int'(e_done));
    chk("R9 aligned_o", int'(aligned), int'(e_al));
    chk("R9 error_o", int'(error), int'(e_err));
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // behavioural reference of one run; start is high before the call
  task automatic run_once(input bit hold);
    logic [7:0] f, prev = 8'h00;
    bit fail = 0, found = 0;
    int tries = 0;
    tick();
    if (!hold) start = 1'b0;
    e_done = 0; e_al = 0; e_err = 0;
    forever begin                     // R2 slip phase, R7 settle spacing
      tick();
      f = frame;
      if (f[3:0] == 4'hC) begin prev = f; break; end
      if (tries == SLIPS) begin fail = 1; break; end
      tries++;
      e_slip = 1;
      tick(); e_slip = 0;
      repeat (SETTLE - 1) tick();
    end
    if (!fail) begin                  // R4 sweep
      e_tap = 0; e_load = 1;
      for (int t = 0; t < 32; t++) begin
        tick(); e_load = 0;
        repeat (SETTLE - 1) tick();
        tick();
        f = frame;
        if (f != prev) begin e_tap = ((t + 1) / 2) + 2; e_load = 1; found = 1; break; end
        prev = f;
        if (t == 31) begin fail = 1; break; end
        e_tap = t + 1; e_load = 1;
      end
    end
    if (!fail && found) begin         // R8 pattern check
      tick(); e_load = 0;
      repeat (SETTLE - 1) tick();
      for (int j = 0; j < CHK; j++) begin
        tick();
        if (ch0 != PAT || ch1 != PAT) begin fail = 1; break; end
      end
    end
    e_done = 1; e_err = fail; e_al = !fail;
    start = 1'b0;
  endtask

  task automatic scenario(input string name, input int need, input int edge_at,
                          input int bad, input bit hold, input bit ok,
                          input int exp_tap, input int exp_pulses);
    slips = 0; cur_tap = 0; edge_tap = edge_at; bad_at = bad;
    base = rotl(8'h0C, 8 - (need % 8));
    @(negedge clk); start = 1'b1;
    run_once(hold);
    chk({name, " R9 aligned"}, int'(aligned), int'(ok));
    chk({name, " R9 error"}, int'(error), int'(!ok));
    chk({name, " R3 pulses"}, slips, exp_pulses);
    if (exp_tap >= 0) chk({name, " R5/R6 final tap"}, int'(tap), exp_tap);
    repeat (3) tick();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 bitslip", int'(bitslip), 0);
    chk("R1 load", int'(tap_load), 0);
    chk("R1 tap", int'(tap), 0);
    chk("R1 status", int'({done, aligned, error}), 0);
    @(posedge clk); #1 rst = 1'b0;
    scenario("aligned at once", 0, 6, -1, 0, 1, 5, 0);          // R2
    scenario("three slips", 3, 1, -1, 0, 1, 3, 3);              // R2 R7
    scenario("slip limit", 4, 31, -1, 0, 1, 18, 4);             // R3 R5 boundary
    scenario("too many slips", 5, 6, -1, 0, 0, -1, 4);          // R3
    scenario("no edge", 2, 99, -1, 0, 0, 31, 2);                // R6
    scenario("first sample bad", 1, 10, 0, 0, 0, 7, 1);         // R8
    scenario("last sample bad", 0, 4, CHK - 1, 0, 0, 4, 0);     // R8
    scenario("bad after window", 1, 20, CHK, 0, 1, 12, 1);      // R8
    scenario("start held", 0, 2, -1, 1, 1, 3, 0);               // R10
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule